// File: doc/BRIEF.md
# Receiver Idle Timeout Counter

This block watches the receive side of a serial port and raises a flag when no character has started for too long. A 10-bit down-counter advances once per bit period, on a one-cycle bit-clock enable from the baud generator. Each time the counter is loaded, it takes an 8-bit programmable limit scaled by four: the limit fills the upper eight bits and the two low bits are cleared. While the counter is armed, every detected start bit loads it again, so it only runs out on a truly idle line.

When the count runs out, a sticky status bit is set and the counter disarms. The interrupt line follows the status bit whenever the mask bit allows it. Software clears the status with a write-one strobe. It must pulse the restart strobe before another timeout can happen. A limit of zero switches the mechanism off completely.

Top module: `rx_idle_timer`

## Requirements
- R1: After reset, the status and interrupt outputs are 0 and the counter is disarmed, so no expiry happens until a restart pulse arrives, whatever the bit ticks and start pulses do.
- R2: A restart pulse arms the counter and loads it with the limit field shifted left by two (low two bits zero). With a nonzero limit L, the status bit is set by the 4*L-th bit tick that follows, so L = 0xFF gives 1020 ticks.
- R3: The count changes only on cycles where the bit-clock enable is 1. Any number of system cycles without a tick leaves the time to expiry unchanged.
- R4: While the limit field is zero, no expiry occurs, the status bit stays 0 and the interrupt stays 0.
- R5: The status bit is set on expiry and stays set through later ticks, start pulses and restarts until it is cleared.
- R6: A status clear pulse clears the status bit one cycle later. If an expiry happens in the same cycle as the clear, the expiry wins and the status stays 1.
- R7: The interrupt output is 1 exactly when the status bit is 1 and the mask bit is 1.
- R8: While the counter is armed, a start-bit pulse reloads it from the limit field, so an expiry then needs 4*L further ticks.
- R9: After an expiry the counter stays disarmed. Start pulses and ticks cause no further expiry until the next restart pulse.
- R10: A restart pulse takes priority over a tick or a start pulse in the same cycle. The count after it is the fresh load, not decremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | One-cycle enable, once per bit period |
| startSeen | input | 1 | One-cycle pulse when the receiver detects a start bit |
| toutField | input | 8 | Programmed timeout limit; 0 disables the timeout |
| restartReq | input | 1 | One-cycle pulse: reload and arm the counter |
| statusClr | input | 1 | One-cycle write-one-to-clear pulse for the status bit |
| intEnable | input | 1 | Interrupt mask bit, 1 lets the interrupt through |
| toutStatus | output | 1 | Sticky timeout status bit |
| toutIrq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: the final bit tick that expires the count, and a status clear from software. The bench first makes the status 1 with a full expiry, then restarts the counter and runs 4*L-1 ticks. It then drives the last tick and the clear pulse in the same cycle and requires the status to read 1 afterwards; a lone clear on the next cycle must then read 0. The bench also drives a restart together with a tick, and checks that the full 4*L ticks are still needed after it.

// File: rtl/rx_idle_pkg.sv
package rx_idle_pkg;

  parameter int CNT_W   = 10;
  parameter int FIELD_W = 8;
  localparam int SCALE_W = CNT_W - FIELD_W;

  // Strobes from the control section into the count datapath
  typedef struct packed {
    logic load;    // take the scaled limit field
    logic decr;    // step down by one
    logic expire;  // last step: force to zero and report
  } ctlStrobes_t;

endpackage

// File: rtl/rx_idle_ctrl.sv
module rx_idle_ctrl
  import rx_idle_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        startSeen,
  input  logic        restartReq,
  input  logic        fieldZero,
  input  logic        atLast,
  output ctlStrobes_t strb,
  output logic        armed
);

  logic armedQ;

  // Priority: restart, then start bit (when armed), then tick
  always_comb begin
    strb = '0;
    if (restartReq) begin
      strb.load = 1'b1;
    end else if (armedQ && startSeen) begin
      strb.load = 1'b1;
    end else if (armedQ && bitTick && !fieldZero) begin
      if (atLast) strb.expire = 1'b1;
      else        strb.decr   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            armedQ <= 1'b0;
    else if (restartReq)  armedQ <= 1'b1;
    else if (strb.expire) armedQ <= 1'b0;
  end

  assign armed = armedQ;

endmodule

// File: rtl/rx_idle_count.sv
module rx_idle_count
  import rx_idle_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strb,
  input  logic [FW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          atLast,
  output logic          fieldZero
);

  localparam int SW = CW - FW;

  logic [CW-1:0] cntQ;
  logic [CW-1:0] loadVal;

  assign loadVal   = {limit, {SW{1'b0}}};
  assign fieldZero = (limit == '0);
  // one step or less remains
  assign atLast    = (cntQ[CW-1:1] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (strb.load)   cntQ <= loadVal;
    else if (strb.expire) cntQ <= '0;
    else if (strb.decr)   cntQ <= cntQ - 1'b1;
  end

  assign count = cntQ;

endmodule

// File: rtl/rx_idle_flag.sv
module rx_idle_flag (
  input  logic clk,
  input  logic rstN,
  input  logic expire,
  input  logic statusClr,
  input  logic intEnable,
  output logic status,
  output logic irq
);

  logic statusQ;

  // expiry outranks a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          statusQ <= 1'b0;
    else if (expire)    statusQ <= 1'b1;
    else if (statusClr) statusQ <= 1'b0;
  end

  assign status = statusQ;
  assign irq    = statusQ & intEnable;

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
  import rx_idle_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitTick,
  input  logic               startSeen,
  input  logic [FIELD_W-1:0] toutField,
  input  logic               restartReq,
  input  logic               statusClr,
  input  logic               intEnable,
  output logic               toutStatus,
  output logic               toutIrq
);

  ctlStrobes_t      strb;
  logic             armedQ;
  logic             atLast;
  logic             fieldZero;
  logic [CNT_W-1:0] cntVal;

  rx_idle_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .startSeen(startSeen),
    .restartReq(restartReq), .fieldZero(fieldZero), .atLast(atLast),
    .strb(strb), .armed(armedQ)
  );

  rx_idle_count #(.CW(CNT_W), .FW(FIELD_W)) u_count (
    .clk(clk), .rstN(rstN), .strb(strb), .limit(toutField),
    .count(cntVal), .atLast(atLast), .fieldZero(fieldZero)
  );

  rx_idle_flag u_flag (
    .clk(clk), .rstN(rstN), .expire(strb.expire), .statusClr(statusClr),
    .intEnable(intEnable), .status(toutStatus), .irq(toutIrq)
  );

endmodule

// File: rtl/rx_idle_timer_chk.sv
module rx_idle_timer_chk
  import rx_idle_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               bitTick,
  input logic               startSeen,
  input logic [FIELD_W-1:0] toutField,
  input logic               restartReq,
  input logic               statusClr,
  input logic               intEnable,
  input logic               toutStatus,
  input logic               toutIrq,
  input logic [CNT_W-1:0]   count,
  input logic               armed,
  input logic               expire
);

  // R2 R10
  restart_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> (armed && count == {$past(toutField), {SCALE_W{1'b0}}}));

  // R3
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bitTick && !restartReq && !startSeen) |=> $stable(count));

  // R4
  zero_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toutStatus) |-> ($past(toutField) != '0));

  // R5
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (toutStatus && !statusClr) |=> toutStatus);

  // R6
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (toutStatus && statusClr && !expire) |=> !toutStatus);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!toutStatus || !intEnable) |-> !toutIrq);

  // R9
  disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> !armed);

  // R9
  idle_when_disarmed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !restartReq) |=> (!armed && $stable(count)));

endmodule

bind rx_idle_timer rx_idle_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .startSeen(startSeen),
  .toutField(toutField), .restartReq(restartReq), .statusClr(statusClr),
  .intEnable(intEnable), .toutStatus(toutStatus), .toutIrq(toutIrq),
  .count(cntVal), .armed(armedQ), .expire(strb.expire)
);

// File: tb/sim_rx_idle_timer.sv
`timescale 1ns/1ps
module sim_rx_idle_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic       startSeen = 1'b0;
  logic [7:0] toutField = 8'd0;
  logic       restartReq = 1'b0;
  logic       statusClr = 1'b0;
  logic       intEnable = 1'b0;
  logic       toutStatus;
  logic       toutIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rx_idle_timer u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .startSeen(startSeen),
    .toutField(toutField), .restartReq(restartReq), .statusClr(statusClr),
    .intEnable(intEnable), .toutStatus(toutStatus), .toutIrq(toutIrq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // each task drives at a falling edge and returns at a falling edge
  task automatic tick();
    @(negedge clk) bitTick = 1'b1;
    @(negedge clk) bitTick = 1'b0;
    @(negedge clk);  // one gap cycle between ticks
  endtask

  task automatic pulseRestart();
    @(negedge clk) restartReq = 1'b1;
    @(negedge clk) restartReq = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk) startSeen = 1'b1;
    @(negedge clk) startSeen = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk) statusClr = 1'b1;
    @(negedge clk) statusClr = 1'b0;
  endtask

  // ticks until status rises, up to limit; returns limit+1 if never
  task automatic ticksToExpiry(input int limit, output int n);
    n = limit + 1;
    for (int i = 1; i <= limit; i++) begin
      tick();
      if (toutStatus) begin
        n = i;
        break;
      end
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 status after reset", toutStatus, 0);
    check("R1 irq after reset", toutIrq, 0);
    rstN = 1'b1;
    toutField = 8'd2;
    intEnable = 1'b1;
    pulseStart();
    ticksToExpiry(20, n);
    check("R1 no expiry before restart", toutStatus, 0);

    // R2: sweep of small limits, period 4*L
    for (int f = 1; f <= 12; f++) begin
      toutField = 8'(f);
      pulseRestart();
      ticksToExpiry(4 * f + 4, n);
      check($sformatf("R2 period for L=%0d", f), n, 4 * f);
      check("R7 irq follows status with mask 1", toutIrq, 1);
      pulseClr();
    end

    // R2: full field
    toutField = 8'hFF;
    pulseRestart();
    ticksToExpiry(1100, n);
    check("R2 period for L=255", n, 1020);
    pulseClr();

    // R7: mask
    intEnable = 1'b0;
    toutField = 8'd1;
    pulseRestart();
    ticksToExpiry(8, n);
    check("R7 status set with mask 0", toutStatus, 1);
    check("R7 irq blocked by mask 0", toutIrq, 0);
    @(negedge clk) intEnable = 1'b1;
    @(negedge clk);
    check("R7 irq rises when mask set", toutIrq, 1);

    // R5 / R9: sticky and disarmed; start pulses ignored
    pulseStart();
    for (int i = 0; i < 10; i++) tick();
    check("R5 status stays set", toutStatus, 1);
    pulseClr();
    check("R6 clear alone", toutStatus, 0);
    pulseStart();
    ticksToExpiry(20, n);
    check("R9 no expiry without restart", toutStatus, 0);

    // R3: idle system cycles without ticks
    toutField = 8'd2;
    pulseRestart();
    repeat (60) @(negedge clk);
    check("R3 no expiry without ticks", toutStatus, 0);
    ticksToExpiry(12, n);
    check("R3 period unchanged by idle cycles", n, 8);
    pulseClr();

    // R8: start bit reloads mid count
    toutField = 8'd3;
    pulseRestart();
    for (int i = 0; i < 7; i++) tick();
    pulseStart();
    ticksToExpiry(20, n);
    check("R8 period after start reload", n, 12);
    pulseClr();

    // R10: restart together with tick
    toutField = 8'd2;
    pulseRestart();
    for (int i = 0; i < 5; i++) tick();
    @(negedge clk) begin restartReq = 1'b1; bitTick = 1'b1; end
    @(negedge clk) begin restartReq = 1'b0; bitTick = 1'b0; end
    ticksToExpiry(12, n);
    check("R10 restart wins over tick", n, 8);

    // R6: clear and expiry in the same cycle; status is 1 here
    pulseRestart();
    for (int i = 0; i < 7; i++) tick();
    check("R6 status still set before collision", toutStatus, 1);
    pulseClr();
    pulseRestart();
    for (int i = 0; i < 7; i++) tick();
    check("R6 no early expiry", toutStatus, 0);
    // make status 1 again through a separate expiry, then collide
    tick();
    check("R6 expiry sets status", toutStatus, 1);
    pulseRestart();
    for (int i = 0; i < 7; i++) tick();
    @(negedge clk) begin bitTick = 1'b1; statusClr = 1'b1; end
    @(negedge clk) begin bitTick = 1'b0; statusClr = 1'b0; end
    check("R6 expiry wins over clear", toutStatus, 1);
    pulseClr();
    check("R6 clear after collision", toutStatus, 0);

    // R4: zero field disables
    toutField = 8'd0;
    pulseRestart();
    ticksToExpiry(1100, n);
    check("R4 no status with zero field", toutStatus, 0);
    check("R4 no irq with zero field", toutIrq, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule